// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets synchronous logic use an asynchronous 16-bit static RAM. The RAM has a 19-bit word address and a separate strobe for each byte lane. The client offers one read or one write at a time on a valid/ready handshake, and a write carries a byte mask. The controller then runs the memory's control lines: chip select, write enable, output enable and the per-lane strobes, all active low. It drives the shared data bus only through a separate drive-enable output. Read data comes back in a register, marked by a single-cycle valid pulse.

The length of each phase is a clock-count parameter: address setup before the write strobe, the data portion of the write pulse, the data hold after the strobe, the read access window, the bus release wait and the idle gap between accesses. The defaults assume a 100 MHz clock and a memory with a 45 ns access time. A write cycle lasts 1+4+1 cycles and a read cycle lasts 5 cycles, so each covers at least 45 ns.

A per-request mode bit picks one of two write styles. In the first, output enable stays high for the whole write. In the second, output enable stays low through the write. The memory then keeps driving the bus for a while after write enable falls, so the controller waits a fixed number of cycles before it drives its own data.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, both bits of `mem_be_n` are high, and `mem_dq_oe` and `rsp_valid` are low.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for a fixed number of cycles and returns high afterwards. That number is SETUP_CYC+PULSE_CYC+HOLD_CYC+GAP_CYC for a write with output enable high, RELEASE_CYC more than that for a write with output enable low, and READ_CYC+GAP_CYC for a read.
- R3: In a write, chip select and the byte strobes go low SETUP_CYC cycles before write enable falls. With output enable held high, write enable then stays low for PULSE_CYC cycles while the write data is driven. After write enable rises, chip select is high and the data stays driven for HOLD_CYC more cycles. While chip select is low, the address and strobes do not change, and write enable never falls without chip select and a strobe.
- R4: Bit 0 of `req_be` selects the lower byte DQ[7:0] through `mem_be_n[0]`, and bit 1 selects the upper byte DQ[15:8] through `mem_be_n[1]`. A strobe goes low only for a set mask bit, and the byte lane that is not selected keeps its old memory contents.
- R5: When `req_oe_low` is 0, `mem_oe_n` stays high for the whole write access.
- R6: When `req_oe_low` is 1, `mem_oe_n` is low from setup until write enable rises. `mem_dq_oe` stays low for the first RELEASE_CYC cycles after write enable falls. Write enable then stays low for PULSE_CYC more cycles with the data driven.
- R7: In a read, write enable stays high and chip select, output enable and the selected strobes are low for READ_CYC cycles. The bus is sampled in the last of those cycles. `rsp_valid` is high for exactly one cycle, the cycle after, with the sampled word on `rsp_rdata`.
- R8: `mem_dq_oe` is never high while the memory may be driving the bus. The memory may be driving when chip select, output enable and a strobe are low, and write enable is either high or has been low for no more than RELEASE_CYC cycles.
- R9: Every access ends with GAP_CYC cycles in which all strobes are high and `mem_dq_oe` is low, before `req_ready` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| req_oe_low | input | 1 | Write style: 1 keeps output enable low during the write |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte strobes, active low, bit 0 lower lane |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Two things can land in the same cycle: the memory letting go of the data bus and the controller starting to drive it. This happens on every write in the output-enable-low style, and most sharply when such a write follows a read directly. The bench provokes it by issuing a read, an output-enable-low write and an output-enable-high write back to back, with no idle time between the requests. Its memory model keeps its output on for exactly the release window after write enable falls. A monitor flags every cycle in which both sides drive at once, and the data read back afterwards shows whether the writes landed intact.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes the sequencer state and the pin decode live in separate modules
// and exchange the state through the enum declared here.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WTURN,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic lane_en;
        logic dq_oe;
    } ctl_pins_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Maps a sequencer state and write style to the memory control levels.
    function automatic ctl_pins_t decode_pins(input seq_state_t st, input logic oe_low);
        ctl_pins_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lane_en: 1'b0, dq_oe: 1'b0};
        case (st)
            ST_WSETUP: begin
                p.cs_n    = 1'b0;
                p.lane_en = 1'b1;
                p.oe_n    = ~oe_low;
                p.dq_oe   = ~oe_low;
            end
            ST_WTURN: begin
                p.cs_n    = 1'b0;
                p.we_n    = 1'b0;
                p.oe_n    = 1'b0;
                p.lane_en = 1'b1;
            end
            ST_WPULSE: begin
                p.cs_n    = 1'b0;
                p.we_n    = 1'b0;
                p.oe_n    = ~oe_low;
                p.lane_en = 1'b1;
                p.dq_oe   = 1'b1;
            end
            ST_WHOLD: begin
                p.dq_oe   = 1'b1;
            end
            ST_RACC: begin
                p.cs_n    = 1'b0;
                p.oe_n    = 1'b0;
                p.lane_en = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks through setup, release wait, write pulse, hold,
// read access and the idle gap, each lasting a parameter number of cycles.
// Assumes every count parameter is at least 1; a zero count is not supported.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 4,
    parameter int HOLD_CYC    = 1,
    parameter int READ_CYC    = 5,
    parameter int GAP_CYC     = 1,
    parameter int RELEASE_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       req_write,
    input  logic       oe_low_q,
    output seq_state_t state_q,
    output seq_state_t state_d,
    output logic       cap_en
);

    localparam int MAXC  = max2(max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, READ_CYC)),
                                max2(GAP_CYC, RELEASE_CYC));
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    function automatic logic [CNT_W-1:0] load(input int n);
        return CNT_W'(n - 1);
    endfunction

    // Next state, next phase count and the read sampling strobe.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cap_en  = 1'b0;
        if (state_q == ST_IDLE) begin
            if (accept) begin
                state_d = req_write ? ST_WSETUP : ST_RACC;
                cnt_d   = req_write ? load(SETUP_CYC) : load(READ_CYC);
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            case (state_q)
                ST_WSETUP: begin
                    state_d = oe_low_q ? ST_WTURN : ST_WPULSE;
                    cnt_d   = oe_low_q ? load(RELEASE_CYC) : load(PULSE_CYC);
                end
                ST_WTURN: begin
                    state_d = ST_WPULSE;
                    cnt_d   = load(PULSE_CYC);
                end
                ST_WPULSE: begin
                    state_d = ST_WHOLD;
                    cnt_d   = load(HOLD_CYC);
                end
                ST_WHOLD: begin
                    state_d = ST_GAP;
                    cnt_d   = load(GAP_CYC);
                end
                ST_RACC: begin
                    state_d = ST_GAP;
                    cnt_d   = load(GAP_CYC);
                    cap_en  = 1'b1;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State and phase counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_req_regs.sv
// Request and response registers: captures address, data, mask and write
// style when a request is taken and holds them until the next one. Samples
// the memory bus on the sequencer's strobe and raises a one-cycle valid.
module sram_req_regs #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_oe_low,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q,
    output logic [LANES-1:0]  be_d,
    output logic              oe_low_q,
    output logic              oe_low_d,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_valid_q
);

    assign be_d     = accept ? req_be : be_q;
    assign oe_low_d = accept ? req_oe_low : oe_low_q;

    // Request fields, loaded only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            oe_low_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
            oe_low_q <= req_oe_low;
        end
    end

    // Read data sample and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= '0;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= cap_en;
            if (cap_en) begin
                rdata_q <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_pin_regs.sv
// Output pin registers: decodes the sequencer's next state into control
// levels and registers them, so every memory control line leaves a flop.
// Assumes state_d, be_d and oe_low_d describe the cycle after the edge.
module sram_pin_regs
    import sram_ctrl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state_d,
    input  logic [LANES-1:0] be_d,
    input  logic             oe_low_d,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [LANES-1:0] be_n,
    output logic             dq_oe
);

    ctl_pins_t nxt;
    assign nxt = decode_pins(state_d, oe_low_d);

    // Shared control lines, inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= nxt.cs_n;
            we_n  <= nxt.we_n;
            oe_n  <= nxt.oe_n;
            dq_oe <= nxt.dq_oe;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane strobe: low only for a masked-in lane in an active phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                be_n[i] <= 1'b1;
            end else begin
                be_n[i] <= ~(nxt.lane_en & be_d[i]);
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller. One request at a time on a
// valid/ready handshake; the data bus is split into out, in and a drive
// enable, to be joined at the pad. Timing parameters count clock cycles.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 4,
    parameter int HOLD_CYC    = 1,
    parameter int READ_CYC    = 5,
    parameter int GAP_CYC     = 1,
    parameter int RELEASE_CYC = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic                req_oe_low,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);

    localparam int LANES = DATA_W / 8;

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             accept;
    logic             cap_en;
    logic [LANES-1:0] be_q;
    logic [LANES-1:0] be_d;
    logic             oe_low_q;
    logic             oe_low_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid & req_ready;

    sram_seq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .READ_CYC   (READ_CYC),
        .GAP_CYC    (GAP_CYC),
        .RELEASE_CYC(RELEASE_CYC)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_write(req_write),
        .oe_low_q (oe_low_q),
        .state_q  (state_q),
        .state_d  (state_d),
        .cap_en   (cap_en)
    );

    sram_req_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .req_oe_low (req_oe_low),
        .cap_en     (cap_en),
        .dq_in      (mem_dq_in),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_out),
        .be_q       (be_q),
        .be_d       (be_d),
        .oe_low_q   (oe_low_q),
        .oe_low_d   (oe_low_d),
        .rdata_q    (rsp_rdata),
        .rsp_valid_q(rsp_valid)
    );

    sram_pin_regs #(
        .LANES(LANES)
    ) pins_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .be_d    (be_d),
        .oe_low_d(oe_low_d),
        .cs_n    (mem_cs_n),
        .we_n    (mem_we_n),
        .oe_n    (mem_oe_n),
        .be_n    (mem_be_n),
        .dq_oe   (mem_dq_oe)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the SRAM controller, attached by bind. Tracks how
// long write enable has been low so that bus contention can be judged.
module sram_ctrl_checker #(
    parameter int ADDR_W  = 19,
    parameter int LANES   = 2,
    parameter int REL_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);

    logic [15:0] we_low_run;

    // Completed cycles of write enable low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_run <= '0;
        end else if (mem_we_n) begin
            we_low_run <= '0;
        end else if (we_low_run != 16'hFFFF) begin
            we_low_run <= we_low_run + 16'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_we_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && !(&mem_be_n)));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_read_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_oe_n && mem_we_n && !(&mem_be_n)) |-> !mem_dq_oe);

    assert_release_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !mem_cs_n && !mem_oe_n) |-> (!mem_we_n && (we_low_run >= 16'(REL_CYC))));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W / 8),
    .REL_CYC(RELEASE_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_be_n (mem_be_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
// Directed bench with a behavioural memory that honours the byte strobes,
// drives the bus only while its output is enabled, and keeps driving for
// the release window after write enable falls.
module sram_async_ctrl_tb_top;

    localparam int AW = 19, DW = 16;
    localparam int S = 1, P = 4, H = 1, R = 5, G = 1, REL = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_write, req_oe_low;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [1:0]    req_be;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]    mem_be_n;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #10 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .READ_CYC(R), .GAP_CYC(G), .RELEASE_CYC(REL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_oe_low(req_oe_low), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_checks = 0, n_errs = 0, contention = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory
    logic [15:0] mem [0:255];
    int          wl_run = 0, rd_run = 0;
    logic        mem_drv;
    logic [15:0] word;

    always_comb begin
        mem_drv = !mem_cs_n && !mem_oe_n && (mem_be_n != 2'b11) && (mem_we_n || wl_run < REL);
        word    = mem[mem_addr[7:0]];
        mem_dq_in = 16'hBAD0;
        if (mem_drv && mem_we_n && rd_run >= R - 1) begin
            mem_dq_in = {mem_be_n[1] ? 8'hEE : word[15:8], mem_be_n[0] ? 8'hEE : word[7:0]};
        end
    end

    always @(posedge clk) begin
        wl_run <= mem_we_n ? 0 : wl_run + 1;
        rd_run <= (!mem_cs_n && !mem_oe_n && mem_we_n && mem_be_n != 2'b11) ? rd_run + 1 : 0;
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    // Bus contention monitor (R8)
    always @(negedge clk) begin
        if (rst_n && mem_dq_oe && mem_drv) contention++;
    end

    // Per-access observations
    int busy, quiet_run, setup, we_low, nodrv, hold, oe_low_any, rsp_cnt, rsp_at;
    int bad_addr, bad_data;
    bit we_seen;
    logic [1:0]  be_seen;
    logic [15:0] rdata_seen;

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] be, input bit mode);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_be = be; req_oe_low = mode;
        while (!req_ready) @(negedge clk);
        busy = 0; quiet_run = 0; setup = 0; we_low = 0; nodrv = 0; hold = 0;
        oe_low_any = 0; rsp_cnt = 0; rsp_at = 0; bad_addr = 0; bad_data = 0;
        we_seen = 1'b0; be_seen = 2'b11; rdata_seen = '0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            if (mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe)
                quiet_run++;
            else
                quiet_run = 0;
            if (wr && !mem_cs_n && mem_we_n && !we_seen) setup++;
            if (!mem_we_n) begin
                we_low++; we_seen = 1'b1;
                if (!mem_dq_oe) nodrv++;
                else if (mem_dq_out != d) bad_data++;
            end
            if (wr && !mem_oe_n) oe_low_any++;
            if (mem_dq_oe && mem_cs_n) hold++;
            if (!mem_cs_n) begin
                be_seen = mem_be_n;
                if (mem_addr != a) bad_addr++;
            end
            if (rsp_valid) begin
                rsp_cnt++; rsp_at = busy; rdata_seen = rsp_rdata;
            end
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(mem_cs_n == 1'b1, "R1", "cs_n", mem_cs_n, 1);
        chk(mem_we_n == 1'b1, "R1", "we_n", mem_we_n, 1);
        chk(mem_oe_n == 1'b1, "R1", "oe_n", mem_oe_n, 1);
        chk(mem_be_n == 2'b11, "R1", "be_n", mem_be_n, 3);
        chk(mem_dq_oe == 1'b0, "R1", "dq_oe", mem_dq_oe, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    endtask

    task automatic test_write_oe_high;
        access(1'b1, 19'h12345, 16'hA5C3, 2'b11, 1'b0);
        chk(busy == S + P + H + G, "R2", "write busy cycles", busy, S + P + H + G);
        chk(setup == S, "R3", "setup cycles", setup, S);
        chk(we_low == P, "R3", "write pulse cycles", we_low, P);
        chk(nodrv == 0, "R3", "pulse cycles without data", nodrv, 0);
        chk(hold == H, "R3", "hold cycles", hold, H);
        chk(bad_data == 0 && bad_addr == 0, "R3", "data/addr mismatches", bad_data + bad_addr, 0);
        chk(oe_low_any == 0, "R5", "oe low cycles in write", oe_low_any, 0);
        chk(quiet_run == G, "R9", "gap after write", quiet_run, G);
        access(1'b0, 19'h12345, 16'h0, 2'b11, 1'b0);
        chk(busy == R + G, "R2", "read busy cycles", busy, R + G);
        chk(we_low == 0, "R7", "we low in read", we_low, 0);
        chk(rsp_cnt == 1, "R7", "valid pulses", rsp_cnt, 1);
        chk(rsp_at == R + 1, "R7", "valid latency", rsp_at, R + 1);
        chk(rdata_seen == 16'hA5C3, "R7", "read data", rdata_seen, 16'hA5C3);
        chk(quiet_run == G, "R9", "gap after read", quiet_run, G);
    endtask

    task automatic test_byte_lanes;
        access(1'b1, 19'h00077, 16'h1234, 2'b11, 1'b0);
        access(1'b1, 19'h00077, 16'h99AA, 2'b01, 1'b0);
        chk(be_seen == 2'b10, "R4", "strobes for lower-only", be_seen, 2'b10);
        access(1'b0, 19'h00077, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'h12AA, "R4", "after lower write", rdata_seen, 16'h12AA);
        access(1'b1, 19'h00077, 16'hBB55, 2'b10, 1'b0);
        chk(be_seen == 2'b01, "R4", "strobes for upper-only", be_seen, 2'b01);
        access(1'b0, 19'h00077, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'hBBAA, "R4", "after upper write", rdata_seen, 16'hBBAA);
    endtask

    task automatic test_oe_low;
        access(1'b1, 19'h2A0F0, 16'h5A69, 2'b11, 1'b1);
        chk(busy == S + REL + P + H + G, "R6", "busy cycles", busy, S + REL + P + H + G);
        chk(nodrv == REL, "R6", "release wait cycles", nodrv, REL);
        chk(we_low == REL + P, "R6", "we low cycles", we_low, REL + P);
        chk(oe_low_any == S + REL + P, "R6", "oe low cycles", oe_low_any, S + REL + P);
        access(1'b0, 19'h2A0F0, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'h5A69, "R6", "read back", rdata_seen, 16'h5A69);
        chk(contention == 0, "R8", "contention cycles", contention, 0);
    endtask

    task automatic test_back_to_back;
        access(1'b0, 19'h12345, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'hA5C3, "R7", "b2b first read", rdata_seen, 16'hA5C3);
        access(1'b1, 19'h00011, 16'hC0DE, 2'b11, 1'b1);
        chk(quiet_run == G, "R9", "gap after oe-low write", quiet_run, G);
        access(1'b1, 19'h00022, 16'hF00D, 2'b11, 1'b0);
        access(1'b0, 19'h00011, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'hC0DE, "R6", "b2b oe-low data", rdata_seen, 16'hC0DE);
        access(1'b0, 19'h00022, 16'h0, 2'b11, 1'b0);
        chk(rdata_seen == 16'hF00D, "R3", "b2b oe-high data", rdata_seen, 16'hF00D);
        chk(contention == 0, "R8", "b2b contention cycles", contention, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_be = 2'b00; req_oe_low = 1'b0;
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_write_oe_high;
        test_byte_lanes;
        test_oe_low;
        test_back_to_back;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog R2: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule